// File: doc/BRIEF.md
# Filtered Bus Transaction Capture Monitor

This block watches a processor-to-fabric register bus and keeps a record of the accesses that matter. It only samples the bus: the read strobe, write strobe, address and data are inputs to it and nothing else. It never drives, stalls or changes the bus. An access is stored only if three conditions hold. Its address must fall inside at least one enabled inclusive window. It must fall outside every enabled exclusive window. Capture must also be open, which means either trigger gating is off or the trigger has already fired. A stored record holds the direction, the address and the data, and goes into a small on-chip FIFO.

A host debug link reaches the monitor through a word-addressed configuration port. Through that port the host programs the windows and the trigger, reads status, drains records one at a time, and issues an arm/clear command before each new capture run. Every setting can be changed while the system runs.

Top module: `bus_capture_mon`

## Requirements
- R1: A qualifying access pushes one record holding its direction (1 = write), address and data. Config word 0x05 reads the oldest record as {dir at bit AW, address at bits AW-1:0}. Word 0x06 reads its data, and a read strobe on 0x06 pops that record. Records come out in arrival order.
- R2: An access qualifies only if its address lies in at least one enabled inclusive window [lo, hi], bounds included. Window i has lo at word 0x10+2i and hi at word 0x11+2i, and its enable is bit i of word 0x0E. A window with lo > hi never matches.
- R3: An address inside any enabled exclusive window is rejected even when an inclusive window covers it. Exclusive window j has lo at word 0x20+2j and hi at word 0x21+2j, and its enable is bit j of word 0x0F. A disabled exclusive window rejects nothing.
- R4: When trigger gating is on (word 0x00 bit 0), nothing is stored until a trigger hit. A hit is an access to the trigger address (word 0x03). The hit access itself is stored if it qualifies. A hit outside the windows still sets the triggered state.
- R5: A read can cause a trigger hit only when word 0x00 bit 1 is set. A write can cause one only when word 0x00 bit 2 is set.
- R6: When word 0x00 bit 3 is set, a trigger hit also needs the bus data to equal word 0x04.
- R7: With word 0x00 bit 0 clear, capture is free-running and every qualifying access is stored.
- R8: The status word 0x02 reads bit 0 triggered, bit 1 FIFO empty, bit 2 FIFO full and bit 3 overflow. After reset it reads 0x2. The FIFO holds DEPTH records.
- R9: A qualifying access that arrives while the FIFO is full is dropped and sets overflow. Overflow stays set until a clear.
- R10: Writing 1 to bit 0 of word 0x01 clears the triggered state, empties the FIFO and clears overflow.
- R11: The configuration words read back what was written and can be rewritten at run time. A new value governs the next bus access.
- R12: A pop strobe while the FIFO is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the monitored bus |
| rst_n | input | 1 | Active-low reset |
| bus_rd | input | 1 | Bus read strobe, one cycle per access |
| bus_wr | input | 1 | Bus write strobe, one cycle per access |
| bus_addr | input | AW | Bus address |
| bus_data | input | DW | Bus data for the access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_re | input | 1 | Configuration read strobe (pops on word 0x06) |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |

## Verification
Overflow is the hardest state to reach from the ports. It needs the windows open and the FIFO filled to exactly DEPTH records, and then one more qualifying access that must be dropped. The stimulus writes DEPTH+1 in-window accesses at consecutive addresses while trigger gating is off. It then drains the FIFO and checks that the dropped access is missing and that overflow is still set. The trigger cases set up two kinds of near-miss first: a read to the trigger address while only writes may trigger, and a data value one off the match value. Only after those does the stimulus issue the real hit.

// File: rtl/bus_capture_mon.sv
module bus_capture_mon #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int NINC  = 2,
  parameter int NEXC  = 2,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          cfg_we,
  input  logic          cfg_re,
  input  logic [7:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata
);
  localparam int PW = $clog2(DEPTH);
  localparam int RW = 1 + AW + DW;

  logic [3:0]      ctrl;
  logic [AW-1:0]   trig_addr;
  logic [DW-1:0]   trig_data;
  logic [NINC-1:0] inc_en, inc_hit;
  logic [NEXC-1:0] exc_en, exc_hit;
  logic [AW-1:0]   inc_lo [NINC];
  logic [AW-1:0]   inc_hi [NINC];
  logic [AW-1:0]   exc_lo [NEXC];
  logic [AW-1:0]   exc_hi [NEXC];
  logic            triggered, ovf;
  logic [RW-1:0]   mem [DEPTH];
  logic [PW:0]     wptr, rptr;
  logic [RW-1:0]   head;

  for (genvar i = 0; i < NINC; i++) begin : g_inc
    assign inc_hit[i] = inc_en[i] && bus_addr >= inc_lo[i] && bus_addr <= inc_hi[i];
  end
  for (genvar j = 0; j < NEXC; j++) begin : g_exc
    assign exc_hit[j] = exc_en[j] && bus_addr >= exc_lo[j] && bus_addr <= exc_hi[j];
  end

  wire xfer      = bus_rd | bus_wr;
  wire in_window = (|inc_hit) && !(|exc_hit);
  wire dir_ok    = (bus_wr && ctrl[2]) || (bus_rd && !bus_wr && ctrl[1]);
  wire trig_hit  = ctrl[0] && dir_ok && bus_addr == trig_addr &&
                   (!ctrl[3] || bus_data == trig_data);
  wire capture   = xfer && in_window && (!ctrl[0] || triggered || trig_hit);
  wire empty     = wptr == rptr;
  wire full      = (wptr[PW] != rptr[PW]) && (wptr[PW-1:0] == rptr[PW-1:0]);
  wire arm       = cfg_we && cfg_addr == 8'h01 && cfg_wdata[0];
  wire pop       = cfg_re && cfg_addr == 8'h06 && !empty;
  wire push      = capture && !full;

  assign head = empty ? '0 : mem[rptr[PW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      trig_addr <= '0;
      trig_data <= '0;
      inc_en    <= '0;
      exc_en    <= '0;
      for (int i = 0; i < NINC; i++) begin
        inc_lo[i] <= '0;
        inc_hi[i] <= '0;
      end
      for (int j = 0; j < NEXC; j++) begin
        exc_lo[j] <= '0;
        exc_hi[j] <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_addr)
        8'h00: ctrl      <= cfg_wdata[3:0];
        8'h03: trig_addr <= cfg_wdata[AW-1:0];
        8'h04: trig_data <= cfg_wdata[DW-1:0];
        8'h0E: inc_en    <= cfg_wdata[NINC-1:0];
        8'h0F: exc_en    <= cfg_wdata[NEXC-1:0];
        default: ;
      endcase
      for (int i = 0; i < NINC; i++) begin
        if (cfg_addr == 8'(16 + 2*i)) inc_lo[i] <= cfg_wdata[AW-1:0];
        if (cfg_addr == 8'(17 + 2*i)) inc_hi[i] <= cfg_wdata[AW-1:0];
      end
      for (int j = 0; j < NEXC; j++) begin
        if (cfg_addr == 8'(32 + 2*j)) exc_lo[j] <= cfg_wdata[AW-1:0];
        if (cfg_addr == 8'(33 + 2*j)) exc_hi[j] <= cfg_wdata[AW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      triggered <= 1'b0;
      ovf       <= 1'b0;
    end else if (arm) begin
      wptr      <= '0;
      rptr      <= '0;
      triggered <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      if (trig_hit) triggered <= 1'b1;
      if (push) wptr <= wptr + 1'b1;
      if (capture && full) ovf <= 1'b1;
      if (pop) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !arm) mem[wptr[PW-1:0]] <= {bus_wr, bus_addr, bus_data};
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      8'h00: cfg_rdata = 32'(ctrl);
      8'h02: cfg_rdata = {28'd0, ovf, full, empty, triggered};
      8'h03: cfg_rdata = 32'(trig_addr);
      8'h04: cfg_rdata = 32'(trig_data);
      8'h05: cfg_rdata = 32'(head[RW-1 -: AW+1]);
      8'h06: cfg_rdata = 32'(head[DW-1:0]);
      8'h0E: cfg_rdata = 32'(inc_en);
      8'h0F: cfg_rdata = 32'(exc_en);
      default: ;
    endcase
    for (int i = 0; i < NINC; i++) begin
      if (cfg_addr == 8'(16 + 2*i)) cfg_rdata = 32'(inc_lo[i]);
      if (cfg_addr == 8'(17 + 2*i)) cfg_rdata = 32'(inc_hi[i]);
    end
    for (int j = 0; j < NEXC; j++) begin
      if (cfg_addr == 8'(32 + 2*j)) cfg_rdata = 32'(exc_lo[j]);
      if (cfg_addr == 8'(33 + 2*j)) cfg_rdata = 32'(exc_hi[j]);
    end
  end
endmodule

// File: rtl/bus_capture_mon_chk.sv
module bus_capture_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic capture,
  input logic pop,
  input logic full,
  input logic empty,
  input logic triggered,
  input logic ovf
);
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> empty && !triggered && !ovf);

  assert_sticky_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !arm |=> ovf);

  assert_drop_sets_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    capture && full && !arm |=> ovf);

  assert_full_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    capture && full && !pop && !arm |=> full);

  assert_status_sane_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  assert_trig_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    triggered && !arm |=> triggered);
endmodule

bind bus_capture_mon bus_capture_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .capture(capture), .pop(pop),
  .full(full), .empty(empty), .triggered(triggered), .ovf(ovf)
);

// File: tb/tb_bus_capture_mon.sv
module tb_bus_capture_mon;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {expect_captured, wr, addr, data}
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 16'h0100, 16'hAAAA},
    {1'b1, 1'b0, 16'h01FF, 16'h1234},
    {1'b0, 1'b1, 16'h00FF, 16'h0001},
    {1'b0, 1'b1, 16'h0200, 16'h0002},
    {1'b0, 1'b1, 16'h0180, 16'h0003},
    {1'b0, 1'b0, 16'h018F, 16'h0004},
    {1'b1, 1'b0, 16'h0190, 16'h0005},
    {1'b1, 1'b1, 16'h040F, 16'h0006},
    {1'b0, 1'b0, 16'h0410, 16'h0007},
    {1'b0, 1'b1, 16'h0300, 16'h0008}
  };

  logic        clk = 0, rst_n = 0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [15:0] bus_addr = 0, bus_data = 0;
  logic        cfg_we = 0, cfg_re = 0;
  logic [7:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  int checks = 0, fails = 0;
  logic [31:0] v;

  bus_capture_mon dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wcfg(logic [7:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rcfg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic popcfg(output logic [31:0] d);
    @(negedge clk); cfg_addr = 8'h06; cfg_re = 1; #1 d = cfg_rdata;
    @(negedge clk); cfg_re = 0;
  endtask

  task automatic xfer(logic wr, logic [15:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_data = d;
    @(negedge clk); bus_wr = 0; bus_rd = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    rcfg(8'h02, v); chk("R8 reset status", v, 32'h2);
    rcfg(8'h00, v); chk("R8 reset ctrl", v, 32'h0);

    wcfg(8'h10, 32'h0100); wcfg(8'h11, 32'h01FF);
    wcfg(8'h12, 32'h0400); wcfg(8'h13, 32'h040F);
    wcfg(8'h20, 32'h0180); wcfg(8'h21, 32'h018F);
    wcfg(8'h22, 32'h0100); wcfg(8'h23, 32'h01FF);
    wcfg(8'h0E, 32'h3);    wcfg(8'h0F, 32'h1);
    rcfg(8'h11, v); chk("R11 readback inc hi", v, 32'h01FF);
    rcfg(8'h0F, v); chk("R11 readback exc en", v, 32'h1);

    // R1 R2 R3 R7 free-running vector walk
    for (int k = 0; k < NVEC; k++) begin
      xfer(VEC[k][32], VEC[k][31:16], VEC[k][15:0]);
      if (VEC[k][33]) begin
        rcfg(8'h05, v); chk("R1 R2 record dir/addr", v, {15'd0, VEC[k][32:16]});
        popcfg(v);      chk("R1 record data", v, {16'd0, VEC[k][15:0]});
      end else begin
        rcfg(8'h02, v); chk("R2 R3 rejected access", v, 32'h2);
      end
      rcfg(8'h02, v); chk("R7 empty after drain", v, 32'h2);
    end

    // R2 inverted window never matches
    wcfg(8'h12, 32'h050F); wcfg(8'h13, 32'h0500);
    xfer(1, 16'h0505, 16'h0); xfer(1, 16'h050F, 16'h0);
    rcfg(8'h02, v); chk("R2 lo>hi no match", v, 32'h2);

    // R8 R9 fill, overflow, order
    for (int k = 0; k < 8; k++) xfer(1, 16'h0100 + 16'(k), 16'h7000 + 16'(k));
    rcfg(8'h02, v); chk("R8 full status", v, 32'h4);
    xfer(1, 16'h0108, 16'h7008);
    rcfg(8'h02, v); chk("R9 overflow set", v, 32'hC);
    for (int k = 0; k < 8; k++) begin
      rcfg(8'h05, v); chk("R1 R8 order addr", v, 32'h10100 + 32'(k));
      popcfg(v);      chk("R9 order data", v, 32'h7000 + 32'(k));
    end
    rcfg(8'h02, v); chk("R9 overflow sticky after drain", v, 32'hA);

    // R12 pop on empty
    popcfg(v);
    rcfg(8'h02, v); chk("R12 pop empty status", v, 32'hA);
    xfer(0, 16'h0123, 16'h4321);
    rcfg(8'h05, v); chk("R12 next record addr", v, 32'h0123);
    popcfg(v);      chk("R12 next record data", v, 32'h4321);

    // R10 clear
    xfer(1, 16'h0111, 16'h1);
    wcfg(8'h01, 32'h1);
    rcfg(8'h02, v); chk("R10 clear", v, 32'h2);

    // R4 R5 write-only trigger
    wcfg(8'h03, 32'h0120); wcfg(8'h00, 32'h5);
    xfer(1, 16'h0110, 16'h1);
    rcfg(8'h02, v); chk("R4 gated before trigger", v, 32'h2);
    xfer(0, 16'h0120, 16'h1);
    rcfg(8'h02, v); chk("R5 read ignored for trigger", v, 32'h2);
    xfer(1, 16'h0120, 16'h2);
    rcfg(8'h02, v); chk("R4 triggered with record", v, 32'h1);
    rcfg(8'h05, v); chk("R4 hit access stored", v, 32'h10120);
    popcfg(v);
    xfer(1, 16'h0130, 16'h3);
    rcfg(8'h05, v); chk("R4 capture after trigger", v, 32'h10130);
    popcfg(v);

    // R6 R5 read trigger with data match
    wcfg(8'h01, 32'h1);
    wcfg(8'h04, 32'h0055); wcfg(8'h00, 32'hB);
    xfer(0, 16'h0120, 16'h0054);
    rcfg(8'h02, v); chk("R6 data mismatch no trigger", v, 32'h2);
    xfer(0, 16'h0120, 16'h0055);
    rcfg(8'h02, v); chk("R6 data match triggers", v, 32'h1);
    rcfg(8'h05, v); chk("R5 read hit record", v, 32'h0120);
    popcfg(v);

    // R4 hit outside windows
    wcfg(8'h01, 32'h1);
    wcfg(8'h03, 32'h0050); wcfg(8'h00, 32'h5);
    xfer(1, 16'h0050, 16'h0);
    rcfg(8'h02, v); chk("R4 trigger outside window", v, 32'h3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule